// File: doc/BRIEF.md
# Trace RAM word unpacker

The block takes 32-bit words read out of a trace capture RAM and turns each word into a run of trace records, one record per clock, with one record for every slot packed into the word. A record holds a 3-bit pipeline status, a packet field of up to 16 bits, a sync flag and a trigger flag. A mode input chooses the trace port width, and that width sets how many slots a word holds. A 4-bit port packs three slots, an 8-bit port packs two, and a 16-bit port packs one.

A word arrives on a valid/ready input and records leave on a valid/ready output. The block latches the word together with the mode, then walks its slots from the lowest bit offset upward. It only accepts the next word when the final slot of the current word is taken downstream. A slot that carries the trace-trigger status is marked as a trigger cycle. Its emitted status is then taken from the low packet bits.

Top module: `trace_word_unpack`

## Requirements
- R1: With mode 0 (4-bit port), a word gives three records from bytes at bit offsets 0, 8 and 16. In each byte, bits [2:0] are the status, bits [6:3] are the packet and bit 7 is the sync flag.
- R2: With mode 1 (8-bit port), a word gives two records from 12-bit slots at offsets 0 and 12. In each slot, bits [2:0] are the status, bits [10:3] are the packet and bit 11 is the sync flag.
- R3: With mode 2 or 3 (16-bit port), a word gives one record. Bits [2:0] are the status, bits [18:3] are the packet and bit 19 is the sync flag.
- R4: Records of a word come out lowest offset first, and exactly as many records as the mode's slot count come out before the output goes idle.
- R5: When a slot's status is 3'b110, the record's status is the packet's low 3 bits and the trigger flag is 1. Otherwise the status passes through unchanged and the trigger flag is 0.
- R6: The packet output is 16 bits, with zeros above the slot's packet width.
- R7: While a record is offered and not taken, the output stays valid with all fields unchanged. An input word is accepted only when no record is pending, or in the cycle the last slot of the current word is taken.
- R8: Word bits above the highest slot used by the mode have no effect on any record.
- R9: The mode is captured with each accepted word. A change of the mode input while a word is being unpacked does not alter that word's records.
- R10: During and after reset, the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2/3 = 16-bit |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word can be accepted |
| in_word_i | input | 32 | Packed trace RAM word |
| out_valid_o | output | 1 | Record valid |
| out_ready_i | input | 1 | Record taken when high with out_valid_o |
| out_stat_o | output | 3 | Pipeline status (trigger-substituted) |
| out_pkt_o | output | 16 | Packet field, zero-extended |
| out_sync_o | output | 1 | Sync flag of the slot |
| out_trig_o | output | 1 | Slot held the trigger status |

## Verification
The hardest situation to reach is the handover edge. The last slot of one word is taken in the same cycle the next word is accepted, while the mode input has already moved to a different width. To reach it, the stimulus loads a 4-bit-mode word, stalls the output with the next word and a new mode already presented, and then releases the output. The third record and the acceptance of the 16-bit word then fall on one edge. The bench checks that the stalled records hold, that the input stays blocked until the last slot, and that the following record uses the new mode with no gap.

// File: rtl/trace_unpack_pkg.sv
package trace_unpack_pkg;

  localparam int STAT_W  = 3;
  localparam int PKT_W   = 16;
  localparam int PKT4_W  = 4;
  localparam int PKT8_W  = 8;
  localparam int PKT16_W = 16;
  localparam int SLOT4_W  = STAT_W + PKT4_W + 1;
  localparam int SLOT8_W  = STAT_W + PKT8_W + 1;
  localparam int SLOT16_W = STAT_W + PKT16_W + 1;
  localparam int N4_SLOTS = 3;
  localparam int N8_SLOTS = 2;
  localparam int USED_W   = N4_SLOTS * SLOT4_W;

  typedef enum logic [1:0] {
    PORT_4   = 2'd0,
    PORT_8   = 2'd1,
    PORT_16  = 2'd2,
    PORT_16B = 2'd3
  } port_mode_e;

  typedef struct packed {
    logic              sync;
    logic [STAT_W-1:0] stat;
    logic [PKT_W-1:0]  pkt;
  } slot_raw_t;

  typedef struct packed {
    logic              trig;
    logic              sync;
    logic [STAT_W-1:0] stat;
    logic [PKT_W-1:0]  pkt;
  } trace_rec_t;

  function automatic logic [1:0] slots_of(port_mode_e m);
    case (m)
      PORT_4:  return 2'd3;
      PORT_8:  return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/tw_slot_seq.sv
module tw_slot_seq
  import trace_unpack_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_mode_e        mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              out_ready_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o,
  output port_mode_e        mode_o,
  output logic [1:0]        slot_o
);

  logic              full_q;
  logic [WORD_W-1:0] word_q;
  port_mode_e        mode_q;
  logic [1:0]        slot_q;
  logic              last_slot;
  logic              in_fire;
  logic              out_fire;

  assign last_slot  = (slot_q == slots_of(mode_q) - 2'd1);
  assign out_fire   = full_q & out_ready_i;
  assign in_ready_o = ~full_q | (out_ready_i & last_slot);
  assign in_fire    = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
      mode_q <= PORT_4;
      slot_q <= '0;
    end else if (in_fire) begin
      // mode is latched here so it only changes at a word boundary
      full_q <= 1'b1;
      word_q <= in_word_i;
      mode_q <= mode_i;
      slot_q <= '0;
    end else if (out_fire) begin
      if (last_slot) full_q <= 1'b0;
      else           slot_q <= slot_q + 2'd1;
    end
  end

  assign full_o = full_q;
  assign word_o = word_q;
  assign mode_o = mode_q;
  assign slot_o = slot_q;

endmodule

// File: rtl/tw_slot_extract.sv
module tw_slot_extract
  import trace_unpack_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  port_mode_e        mode_i,
  input  logic [1:0]        slot_i,
  output slot_raw_t         raw_o
);

  slot_raw_t lane4 [N4_SLOTS];
  slot_raw_t lane8 [N8_SLOTS];
  slot_raw_t lane16;

  for (genvar g = 0; g < N4_SLOTS; g++) begin : g_lane4
    localparam int B = g * SLOT4_W;
    assign lane4[g] = '{sync: word_i[B+STAT_W+PKT4_W],
                        stat: word_i[B +: STAT_W],
                        pkt:  PKT_W'(word_i[B+STAT_W +: PKT4_W])};
  end

  for (genvar g = 0; g < N8_SLOTS; g++) begin : g_lane8
    localparam int B = g * SLOT8_W;
    assign lane8[g] = '{sync: word_i[B+STAT_W+PKT8_W],
                        stat: word_i[B +: STAT_W],
                        pkt:  PKT_W'(word_i[B+STAT_W +: PKT8_W])};
  end

  assign lane16 = '{sync: word_i[STAT_W+PKT16_W],
                    stat: word_i[0 +: STAT_W],
                    pkt:  word_i[STAT_W +: PKT16_W]};

  // bits above the widest packing are never looked at
  logic unused_hi_bits;
  assign unused_hi_bits = ^word_i[WORD_W-1:USED_W];

  always_comb begin
    raw_o = lane16;
    case (mode_i)
      PORT_4: begin
        case (slot_i)
          2'd0:    raw_o = lane4[0];
          2'd1:    raw_o = lane4[1];
          default: raw_o = lane4[2];
        endcase
      end
      PORT_8: raw_o = slot_i[0] ? lane8[1] : lane8[0];
      default: raw_o = lane16;
    endcase
  end

endmodule

// File: rtl/tw_trig_rewrite.sv
module tw_trig_rewrite
  import trace_unpack_pkg::*;
#(
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  slot_raw_t  raw_i,
  output trace_rec_t rec_o
);

  logic hit;
  assign hit = (raw_i.stat == TRIG_CODE);

  always_comb begin
    rec_o.pkt  = raw_i.pkt;
    rec_o.sync = raw_i.sync;
    rec_o.trig = hit;
    rec_o.stat = hit ? raw_i.pkt[STAT_W-1:0] : raw_i.stat;
  end

endmodule

// File: rtl/trace_word_unpack.sv
module trace_word_unpack
  import trace_unpack_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [STAT_W-1:0] out_stat_o,
  output logic [PKT_W-1:0]  out_pkt_o,
  output logic              out_sync_o,
  output logic              out_trig_o
);

  logic              full;
  logic [WORD_W-1:0] word_q;
  port_mode_e        mode_q;
  logic [1:0]        slot_q;
  slot_raw_t         raw;
  trace_rec_t        rec;

  tw_slot_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (port_mode_e'(mode_i)),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_word_i   (in_word_i),
    .out_ready_i (out_ready_i),
    .full_o      (full),
    .word_o      (word_q),
    .mode_o      (mode_q),
    .slot_o      (slot_q)
  );

  tw_slot_extract #(.WORD_W(WORD_W)) u_ext (
    .word_i (word_q),
    .mode_i (mode_q),
    .slot_i (slot_q),
    .raw_o  (raw)
  );

  tw_trig_rewrite #(.TRIG_CODE(TRIG_CODE)) u_trig (
    .raw_i (raw),
    .rec_o (rec)
  );

  assign out_valid_o = full;
  assign out_stat_o  = rec.stat;
  assign out_pkt_o   = rec.pkt;
  assign out_sync_o  = rec.sync;
  assign out_trig_o  = rec.trig;

endmodule

// File: rtl/tw_unpack_chk.sv
module tw_unpack_chk
  import trace_unpack_pkg::*;
#(
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [STAT_W-1:0] out_stat_o,
  input logic [PKT_W-1:0]  out_pkt_o,
  input logic              out_sync_o,
  input logic              out_trig_o
);

  port_mode_e chk_mode;
  logic [1:0] chk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_mode <= PORT_4;
      chk_cnt  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      chk_mode <= port_mode_e'(mode_i);
      chk_cnt  <= '0;
    end else if (out_valid_o && out_ready_i) begin
      chk_cnt  <= chk_cnt + 2'd1;
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o &&
      $stable({out_stat_o, out_pkt_o, out_sync_o, out_trig_o}));

  a_r7_accept_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && out_valid_o |-> out_ready_i);

  a_r10_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r5_no_raw_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_trig_o |-> out_stat_o != TRIG_CODE);

  a_r6_zero_ext_4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && chk_mode == PORT_4 |-> out_pkt_o[PKT_W-1:PKT4_W] == '0);

  a_r6_zero_ext_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && chk_mode == PORT_8 |-> out_pkt_o[PKT_W-1:PKT8_W] == '0);

  a_r4_last_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && in_ready_o |-> chk_cnt == slots_of(chk_mode) - 2'd1);

  a_r4_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_ready_o |-> chk_cnt < slots_of(chk_mode) - 2'd1);

endmodule

bind trace_word_unpack tw_unpack_chk #(.TRIG_CODE(TRIG_CODE)) u_chk (.*);

// File: tb/trace_word_unpack_test.sv
`timescale 1ns/1ps
module trace_word_unpack_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_stat;
  logic [15:0] out_pkt;
  logic        out_sync;
  logic        out_trig;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trace_word_unpack uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_word_i   (in_word),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_stat_o  (out_stat),
    .out_pkt_o   (out_pkt),
    .out_sync_o  (out_sync),
    .out_trig_o  (out_trig)
  );

  // entry: {word[32], mode[2], nrec[2], r0[21], r1[21], r2[21]}; rec = {trig, sync, stat[3], pkt[16]}
  localparam logic [98:0] TAB [8] = '{
    {32'hFF832A05, 2'd0, 2'd3, {1'b0,1'b0,3'd5,16'h0000}, {1'b0,1'b0,3'd2,16'h0005}, {1'b0,1'b1,3'd3,16'h0000}},
    {32'h000600DE, 2'd0, 2'd3, {1'b1,1'b1,3'd3,16'h000B}, {1'b0,1'b0,3'd0,16'h0000}, {1'b1,1'b0,3'd0,16'h0000}},
    {32'hA57FE8F1, 2'd1, 2'd2, {1'b0,1'b1,3'd1,16'h001E}, {1'b1,1'b0,3'd7,16'h00FF}, 21'd0},
    {32'hABCFFFF8, 2'd2, 2'd1, {1'b0,1'b1,3'd0,16'hFFFF}, 21'd0, 21'd0},
    {32'h0001234E, 2'd3, 2'd1, {1'b1,1'b0,3'd1,16'h2469}, 21'd0, 21'd0},
    {32'hFFFFFFFF, 2'd0, 2'd3, {1'b0,1'b1,3'd7,16'h000F}, {1'b0,1'b1,3'd7,16'h000F}, {1'b0,1'b1,3'd7,16'h000F}},
    {32'hFFFFFFFF, 2'd1, 2'd2, {1'b0,1'b1,3'd7,16'h00FF}, {1'b0,1'b1,3'd7,16'h00FF}, 21'd0},
    {32'h00000000, 2'd2, 2'd1, {1'b0,1'b0,3'd0,16'h0000}, 21'd0, 21'd0}
  };

  task automatic chk_rec(input string tag, input logic [20:0] exp);
    logic [21:0] got;
    got = {out_valid, out_trig, out_sync, out_stat, out_pkt};
    checks++;
    if (got !== {1'b1, exp}) begin
      fails++;
      $display("FAIL %s: got v/rec=%h expected %h", tag, got, {1'b1, exp});
    end
  endtask

  task automatic chk_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; mode = 2'd0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R10 out_valid in reset", out_valid, 1'b0);
    chk_bit("R10 in_ready in reset", in_ready, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_bit("R10 out_valid after reset", out_valid, 1'b0);

    // table walk: R1 R2 R3 R4 R5 R6 R8 (upper word bits set in several entries)
    for (int i = 0; i < 8; i++) begin
      string tag;
      logic [1:0] n;
      tag = (TAB[i][66:65] == 2'd0) ? "R1" : (TAB[i][66:65] == 2'd1) ? "R2" : "R3";
      n = TAB[i][64:63];
      in_word = TAB[i][98:67]; mode = TAB[i][66:65]; in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
        if (k < int'(n)) begin
          chk_rec($sformatf("%s/R5 entry %0d slot %0d", tag, i, k), TAB[i][62 - 21*k -: 21]);
          @(posedge clk);
          @(negedge clk);
        end
      end
      chk_bit($sformatf("R4 idle after entry %0d", i), out_valid, 1'b0);
    end

    // stall, mode change mid-word, same-edge handover: R7 R9
    in_word = 32'h001F0E0B; mode = 2'd0; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_word = 32'hABCFFFF8; mode = 2'd2;
    chk_bit("R7 in blocked while busy", in_ready, 1'b0);
    chk_rec("R7 stalled slot 0", {1'b0,1'b0,3'd3,16'h0001});
    @(posedge clk);
    @(negedge clk);
    chk_rec("R7 slot 0 held", {1'b0,1'b0,3'd3,16'h0001});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_rec("R9 slot 1 old mode", {1'b1,1'b0,3'd1,16'h0001});
    chk_bit("R7 in blocked mid-word", in_ready, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk_rec("R9 slot 2 old mode", {1'b0,1'b0,3'd7,16'h0003});
    chk_bit("R7 in ready at last slot", in_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_rec("R9 next word new mode", {1'b0,1'b1,3'd0,16'hFFFF});
    @(posedge clk);
    @(negedge clk);
    chk_bit("R4 idle after handover", out_valid, 1'b0);

    // reset in the middle of a word: R10
    in_word = 32'h001F0E0B; mode = 2'd0; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk_bit("R10 mid-word reset drops valid", out_valid, 1'b0);
    chk_bit("R10 mid-word reset ready", in_ready, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    in_word = 32'hFFFFFFFF; mode = 2'd1; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_rec("R2 slot 0 after reset", {1'b0,1'b1,3'd7,16'h00FF});
    @(posedge clk);
    @(negedge clk);
    chk_rec("R2 slot 1 after reset", {1'b0,1'b1,3'd7,16'h00FF});
    @(posedge clk);
    @(negedge clk);
    chk_bit("R4 idle after reset word", out_valid, 1'b0);

    finish_run();
  end

endmodule